// File: doc/BRIEF.md
# Atomic Read-Modify-Write Completer

This block executes atomic memory requests against a word-wide local memory that sits outside it behind a simple synchronous port. A request names one of three operations: add-and-fetch, unconditional exchange, or compare-and-exchange. It also carries a word address, a primary operand (the addend or the replacement value), a comparand, and a width select.

For every accepted request the block reads the addressed word and computes the replacement. It writes the result back only when the operation calls for it, and returns the value the word held before the operation as a one-cycle completion. The read, the completion and the write-back of one request are never interleaved with any other memory access, because the block takes no new request until the write-back slot of the current one has passed.

Narrow (32-bit) operations act on the low half of the 64-bit memory word and keep the high half. Wide (64-bit) operations act on the whole word. The reserved opcode produces an error completion and no write.

Top module: `amo_completer`

## Requirements
- R1: After reset `req_ready_o` is 1 while `cpl_valid_o`, `cpl_err_o`, `mem_req_o` and `mem_we_o` are 0.
- R2: Opcode 2'b00 (add) writes the old value plus `req_opa_i` to the addressed word and returns the old value.
- R3: Opcode 2'b01 (exchange) writes `req_opa_i` to the addressed word without condition and returns the old value.
- R4: Opcode 2'b10 (compare-exchange) writes `req_opa_i` only when `req_opb_i` equals the old value; otherwise no write strobe is raised and the word keeps its value. The old value is returned in both cases.
- R5: `cpl_data_o` carries the value read before any change; for a narrow request it is the old low 32 bits, zero-extended.
- R6: With `req_wide_i` = 0, only bits 31:0 take part in the add, compare or exchange, the add wraps modulo 2^32, and bits 63:32 of the word are written back unchanged.
- R7: With `req_wide_i` = 1, the add wraps modulo 2^64.
- R8: The read strobe (`mem_req_o`=1, `mem_we_o`=0) is raised in the cycle after acceptance, and the completion appears in the cycle after the read together with any write strobe, which targets the same address. Each request raises at most one write.
- R9: `req_ready_o` drops in the cycle after acceptance and rises again only in the cycle after the completion/write-back cycle; while ready is high, the memory port is idle.
- R10: Opcode 2'b11 gives a completion with `cpl_err_o`=1 and `cpl_data_o`=0, and raises no write.
- R11: `cpl_valid_o` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_op_i | input | 2 | 00 add, 01 exchange, 10 compare-exchange, 11 reserved |
| req_wide_i | input | 1 | 1: 64-bit operation, 0: 32-bit on low half |
| req_addr_i | input | ADDR_W | Word address |
| req_opa_i | input | DATA_W | Addend or replacement value |
| req_opb_i | input | DATA_W | Comparand for compare-exchange |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Write qualifier for the strobe |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid the cycle after a read strobe |
| cpl_valid_o | output | 1 | Completion present |
| cpl_data_o | output | DATA_W | Pre-operation value |
| cpl_err_o | output | 1 | Reserved opcode completion |

## Verification
The completion and the write-back fall in the same cycle, and both are driven from data that arrived from memory only at that cycle's start. Each directed scenario samples that one cycle and checks the returned value, the write strobe and its address against a model of the expected old and new words. One cycle later the bench reads the word from its own memory model, so a write that is missing, extra or misplaced shows up as a wrong stored value. Compare-exchange hit and miss, narrow carry into the high half, and the reserved opcode are what make the write side of that shared cycle differ from the completion side.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [1:0] {
    AMO_ADD  = 2'b00,
    AMO_XCHG = 2'b01,
    AMO_CAS  = 2'b10,
    AMO_RSVD = 2'b11
  } amo_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_EXEC = 2'd2
  } amo_state_e;
endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned NARROW_W = 32
) (
  input  amo_op_e             op_i,
  input  logic                wide_i,
  input  logic [DATA_W-1:0]   old_i,
  input  logic [DATA_W-1:0]   opa_i,
  input  logic [DATA_W-1:0]   opb_i,
  output logic [DATA_W-1:0]   new_o,
  output logic [DATA_W-1:0]   ret_o,
  output logic                wr_o,
  output logic                err_o
);
  localparam int unsigned HI_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0]   sum_w;
  logic [NARROW_W-1:0] sum_n;
  logic                eq_w, eq_n;
  logic [DATA_W-1:0]   res_w;
  logic [NARROW_W-1:0] res_n;

  assign sum_w = old_i + opa_i;
  assign sum_n = old_i[NARROW_W-1:0] + opa_i[NARROW_W-1:0];
  assign eq_w  = (old_i == opb_i);
  assign eq_n  = (old_i[NARROW_W-1:0] == opb_i[NARROW_W-1:0]);

  always_comb begin
    res_w = opa_i;
    res_n = opa_i[NARROW_W-1:0];
    wr_o  = 1'b0;
    err_o = 1'b0;
    unique case (op_i)
      AMO_ADD: begin
        res_w = sum_w;
        res_n = sum_n;
        wr_o  = 1'b1;
      end
      AMO_XCHG: wr_o = 1'b1;
      AMO_CAS:  wr_o = wide_i ? eq_w : eq_n;
      default:  err_o = 1'b1;
    endcase
  end

  assign new_o = wide_i ? res_w : {old_i[DATA_W-1:NARROW_W], res_n};

  always_comb begin
    if (err_o)       ret_o = '0;
    else if (wide_i) ret_o = old_i;
    else             ret_o = {{HI_W{1'b0}}, old_i[NARROW_W-1:0]};
  end
endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  output logic ready_o,
  output logic capture_o,
  output logic rd_phase_o,
  output logic ex_phase_o
);
  amo_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) state_d = ST_READ;
      ST_READ: state_d = ST_EXEC;
      ST_EXEC: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign ready_o    = (state_q == ST_IDLE);
  assign capture_o  = ready_o & req_valid_i;
  assign rd_phase_o = (state_q == ST_READ);
  assign ex_phase_o = (state_q == ST_EXEC);
endmodule

// File: rtl/amo_completer.sv
module amo_completer
  import amo_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned NARROW_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic              req_wide_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_opa_i,
  input  logic [DATA_W-1:0] req_opb_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              cpl_valid_o,
  output logic [DATA_W-1:0] cpl_data_o,
  output logic              cpl_err_o
);
  logic              capture, rd_phase, ex_phase;
  amo_op_e           op_q;
  logic              wide_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] opa_q, opb_q;
  logic [DATA_W-1:0] new_word, ret_word;
  logic              do_wr, op_err;

  amo_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .ready_o    (req_ready_o),
    .capture_o  (capture),
    .rd_phase_o (rd_phase),
    .ex_phase_o (ex_phase)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= AMO_RSVD;
      wide_q <= 1'b0;
      addr_q <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
    end else if (capture) begin
      op_q   <= amo_op_e'(req_op_i);
      wide_q <= req_wide_i;
      addr_q <= req_addr_i;
      opa_q  <= req_opa_i;
      opb_q  <= req_opb_i;
    end
  end

  amo_alu #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_alu (
    .op_i  (op_q),
    .wide_i(wide_q),
    .old_i (mem_rdata_i),
    .opa_i (opa_q),
    .opb_i (opb_q),
    .new_o (new_word),
    .ret_o (ret_word),
    .wr_o  (do_wr),
    .err_o (op_err)
  );

  // completion and write-back share the cycle after the read
  assign mem_we_o    = ex_phase & do_wr;
  assign mem_req_o   = rd_phase | mem_we_o;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = new_word;
  assign cpl_valid_o = ex_phase;
  assign cpl_data_o  = ex_phase ? ret_word : '0;
  assign cpl_err_o   = ex_phase & op_err;
endmodule

// File: rtl/amo_completer_chk.sv
module amo_completer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic mem_req_o,
  input logic mem_we_o,
  input logic cpl_valid_o,
  input logic cpl_err_o
);
  AST_WE_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);  // R8
  AST_WRITE_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_req_o && !mem_we_o));  // R8
  AST_CPL_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o |-> $past(mem_req_o && !mem_we_o));  // R8
  AST_WRITE_WITH_CPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> cpl_valid_o);  // R8
  AST_ERR_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_err_o |-> (cpl_valid_o && !mem_we_o));  // R10
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);  // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o);  // R9
  AST_CPL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o |=> !cpl_valid_o);  // R11
endmodule

bind amo_completer amo_completer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .cpl_valid_o(cpl_valid_o),
  .cpl_err_o  (cpl_err_o)
);

// File: tb/amo_completer_bench.sv
`timescale 1ns/1ps
module amo_completer_bench;
  localparam int AW = 8;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'b00;
  logic          req_wide = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_opa = '0, req_opb = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          cpl_valid, cpl_err;
  logic [DW-1:0] cpl_data;
  logic [DW-1:0] mem [0:(1<<AW)-1];

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  amo_completer #(.ADDR_W(AW), .DATA_W(DW), .NARROW_W(32)) u_amo_completer (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_wide_i(req_wide), .req_addr_i(req_addr),
    .req_opa_i(req_opa), .req_opb_i(req_opb),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .cpl_valid_o(cpl_valid), .cpl_data_o(cpl_data), .cpl_err_o(cpl_err)
  );

  task automatic chk(input string rq, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // one request end to end; rq names the requirement the data checks cover
  task automatic do_amo(input logic [1:0] op, input logic wide, input logic [AW-1:0] addr,
                        input logic [DW-1:0] a, input logic [DW-1:0] b, input string rq);
    logic [DW-1:0] old, e_new, e_ret;
    logic e_we, e_err;
    old   = mem[addr];
    e_we  = 1'b0;
    e_err = 1'b0;
    e_new = old;
    e_ret = wide ? old : {32'h0, old[31:0]};
    case (op)
      2'b00: begin
        e_we  = 1'b1;
        e_new = wide ? old + a : {old[63:32], old[31:0] + a[31:0]};
      end
      2'b01: begin
        e_we  = 1'b1;
        e_new = wide ? a : {old[63:32], a[31:0]};
      end
      2'b10: begin
        e_we  = wide ? (old == b) : (old[31:0] == b[31:0]);
        if (e_we) e_new = wide ? a : {old[63:32], a[31:0]};
      end
      default: begin
        e_err = 1'b1;
        e_ret = '0;
      end
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_wide = wide; req_addr = addr; req_opa = a; req_opb = b;
    chk("R9", "ready before accept", 64'(req_ready), 64'd1);
    chk("R9", "port idle while ready", 64'(mem_req), 64'd0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "ready low after accept", 64'(req_ready), 64'd0);
    chk("R8", "read strobe", {62'd0, mem_req, mem_we}, 64'd2);
    chk("R8", "read address", 64'(mem_addr), 64'(addr));
    @(negedge clk);
    chk("R11", "completion valid", 64'(cpl_valid), 64'd1);
    chk(rq, "completion data", cpl_data, e_ret);
    chk("R10", "error flag", 64'(cpl_err), 64'(e_err));
    chk("R8", "write strobe", {62'd0, mem_req & mem_we, mem_we}, {62'd0, e_we, e_we});
    if (e_we) chk("R8", "write address", 64'(mem_addr), 64'(addr));
    @(negedge clk);
    chk("R11", "completion single cycle", 64'(cpl_valid), 64'd0);
    chk("R9", "ready after write-back", 64'(req_ready), 64'd1);
    chk(rq, "stored word", mem[addr], e_new);
  endtask

  task automatic t_reset();
    chk("R1", "ready", 64'(req_ready), 64'd1);
    chk("R1", "cpl_valid", 64'(cpl_valid), 64'd0);
    chk("R1", "cpl_err", 64'(cpl_err), 64'd0);
    chk("R1", "mem strobes", {62'd0, mem_req, mem_we}, 64'd0);
  endtask

  task automatic t_add_wide();
    mem[8'h10] = 64'h0000_0001_0000_0005;
    do_amo(2'b00, 1'b1, 8'h10, 64'h0000_0002_0000_0003, '0, "R2");
    mem[8'h11] = 64'hFFFF_FFFF_FFFF_FFFF;
    do_amo(2'b00, 1'b1, 8'h11, 64'd2, '0, "R7");
  endtask

  task automatic t_add_narrow();
    mem[8'h20] = 64'hAAAA_5555_FFFF_FFFF;
    do_amo(2'b00, 1'b0, 8'h20, 64'h1234_0000_0000_0002, '0, "R6");
    mem[8'h21] = 64'h0000_0007_8000_0000;
    do_amo(2'b00, 1'b0, 8'h21, 64'h0000_0000_0000_0010, '0, "R5");
  endtask

  task automatic t_xchg();
    mem[8'h30] = 64'hDEAD_BEEF_CAFE_F00D;
    do_amo(2'b01, 1'b1, 8'h30, 64'h0123_4567_89AB_CDEF, '0, "R3");
    do_amo(2'b01, 1'b0, 8'h30, 64'hFFFF_FFFF_1111_2222, '0, "R6");
  endtask

  task automatic t_cas();
    mem[8'h40] = 64'h0000_0000_0000_0042;
    do_amo(2'b10, 1'b1, 8'h40, 64'h77, 64'h42, "R4");
    do_amo(2'b10, 1'b1, 8'h40, 64'h99, 64'h42, "R4");
    mem[8'h41] = 64'h5555_0000_0000_0009;
    do_amo(2'b10, 1'b0, 8'h41, 64'h0000_0000_0000_0001, 64'hFFFF_0000_0000_0009, "R6");
    do_amo(2'b10, 1'b1, 8'h41, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0001, "R4");
  endtask

  task automatic t_rsvd();
    mem[8'h50] = 64'h1111_2222_3333_4444;
    do_amo(2'b11, 1'b1, 8'h50, 64'hFF, 64'h1111_2222_3333_4444, "R10");
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add_wide();
    t_add_narrow();
    t_xchg();
    t_cas();
    t_rsvd();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule